// File: doc/BRIEF.md
# Single-Wire Pulse-Width Data Transmitter

The block carries one data word per PWM period over a single output wire. Each period begins with a rising edge at a fixed position (the first cycle of the period). The pulse stays high for a number of clock cycles that grows linearly with the word. Word zero gives about one tenth of the period and the largest word gives about nine tenths, so a receiver always sees a pulse of some minimum width. A receiver recovers the word from the ratio of high time to period.

Words arrive on a valid/ready stream into a shadow register. The period length, in clock cycles, is a plain input. At each period boundary the shadow word and the period input are turned into an integer compare value and copied into the active registers together. A period already running is therefore never disturbed. Transmission runs without gaps: if no new word has arrived, the last one is sent again. Back-pressure is minimal. `in_ready` is low only while reset is asserted and high from the first cycle after it. A transfer happens on any clock edge where `in_valid` and `in_ready` are both high. A later word simply replaces an earlier one that has not yet been sent.

Top module: `pwm_duty_tx`

## Requirements
- R1: With N the word width, c the word and P the period, the high time of a period is H = floor((P*(2^N + 8*c) + 5*2^N) / (10*2^N)) clock cycles. This is P*(0.1 + 0.8*c/2^N) rounded to nearest, with halves rounded up.
- R2: Each period lasts exactly P clock cycles. `pwm_out` is high for its first H cycles and low for the remaining P-H cycles, so the rising edge is always at the period start.
- R3: `in_ready` is 0 during reset and 1 from the first clock after reset. A word is taken into the shadow register on an edge with `in_valid` and `in_ready` both 1. While `in_valid` is 0, `in_data` is ignored.
- R4: The word and `period` are sampled only at a period start. A new word or period that arrives mid-period leaves the current period's high time and length unchanged, and applies from the next period start.
- R5: When no new word arrives, every following period repeats the same high time and length.
- R6: After a clock edge that samples `en` low, `pwm_out` is 0 and the period counter is cleared. The first edge that samples `en` high starts a fresh period, so `pwm_out` is 1 in the cycle that follows.
- R7: Reset drives `pwm_out` to 0 and sets the shadow word to 0. Words accepted while `en` is low are kept and are used by the first period after enabling.
- R8: For P of at least 10, the active compare value is non-zero and strictly below P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the output low and clears the counter |
| period | input | PER_W | Period length in clock cycles, at least 10 |
| in_valid | input | 1 | Data word valid |
| in_ready | output | 1 | Ready to accept a data word |
| in_data | input | DATA_W | Data word to send |
| pwm_out | output | 1 | Pulse-width encoded output line |

## Verification
`pwm_out` comes from a register, so a period that starts on an edge shows its first high cycle immediately after that edge. The bench samples every output on the falling clock edge. A disable or re-enable therefore shows at the first falling edge after the rising edge that sampled `en`. A word accepted on an edge can apply no earlier than the next period start, so after each transfer the bench lets one rising edge of `pwm_out` pass and then measures the next full period. Its high count and length are compared with R1 and the driven period. For the double-buffer cases, the period that is running when the new word arrives is measured and compared with the old values.

// File: rtl/pwm_tx_pkg.sv
package pwm_tx_pkg;
  typedef enum logic {
    GEN_OFF = 1'b0,
    GEN_ON  = 1'b1
  } gen_state_e;

  // Smallest period for which the 10%..90% window stays inside (0, P).
  localparam int unsigned MIN_PERIOD = 10;
endpackage

// File: rtl/pwm_word_shadow.sv
module pwm_word_shadow #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] code_o
);
  logic              ready_q;
  logic [DATA_W-1:0] code_q;

  // Always ready outside reset; a newer word replaces an unsent one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      code_q  <= '0;
    end else begin
      ready_q <= 1'b1;
      if (in_valid && ready_q) begin
        code_q <= in_data;
      end
    end
  end

  assign in_ready = ready_q;
  assign code_o   = code_q;
endmodule

// File: rtl/pwm_cmp_calc.sv
module pwm_cmp_calc #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned PER_W  = 16
) (
  input  logic [DATA_W-1:0] code_i,
  input  logic [PER_W-1:0]  period_i,
  output logic [PER_W-1:0]  cmp_o
);
  // duty = (2^N + 8c) / (10 * 2^N); 10 * 2^N = 5 * 2^(N+1)
  localparam int unsigned WT_W  = DATA_W + 4;
  localparam int unsigned NUM_W = PER_W + WT_W + 1;
  localparam int unsigned Q_W   = NUM_W - (DATA_W + 1);

  logic [WT_W-1:0]  weight;
  logic [NUM_W-1:0] num;
  logic [Q_W-1:0]   q_pow2;

  assign weight = (WT_W'(1) << DATA_W) + {1'b0, code_i, 3'b000};
  // Half of the divisor is added before truncation for round-to-nearest.
  assign num    = NUM_W'(period_i) * NUM_W'(weight) + (NUM_W'(5) << DATA_W);
  assign q_pow2 = Q_W'(num >> (DATA_W + 1));
  assign cmp_o  = PER_W'(q_pow2 / Q_W'(5));
endmodule

// File: rtl/pwm_period_gen.sv
module pwm_period_gen
  import pwm_tx_pkg::*;
#(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PER_W-1:0] period_i,
  input  logic [PER_W-1:0] cmp_i,
  output logic             pwm_o
);
  gen_state_e       state_q;
  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] act_per_q;
  logic [PER_W-1:0] act_cmp_q;
  logic             pwm_q;
  logic [PER_W-1:0] cnt_inc;
  logic             wrap;

  assign cnt_inc = cnt_q + PER_W'(1);
  assign wrap    = (state_q == GEN_ON) && (cnt_q == act_per_q - PER_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= GEN_OFF;
      cnt_q     <= '0;
      act_per_q <= '0;
      act_cmp_q <= '0;
      pwm_q     <= 1'b0;
    end else if (!en) begin
      state_q <= GEN_OFF;
      cnt_q   <= '0;
      pwm_q   <= 1'b0;
    end else if (state_q == GEN_OFF || wrap) begin
      // Period start: shadow-to-active transfer, rising edge.
      state_q   <= GEN_ON;
      cnt_q     <= '0;
      act_per_q <= period_i;
      act_cmp_q <= cmp_i;
      pwm_q     <= (cmp_i != '0);
    end else begin
      cnt_q <= cnt_inc;
      pwm_q <= (cnt_inc < act_cmp_q);
    end
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/pwm_duty_tx.sv
module pwm_duty_tx #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned PER_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [PER_W-1:0]  period,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              pwm_out
);
  logic [DATA_W-1:0] shadow_code;
  logic [PER_W-1:0]  next_cmp;

  pwm_word_shadow #(.DATA_W(DATA_W)) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .code_o   (shadow_code)
  );

  pwm_cmp_calc #(.DATA_W(DATA_W), .PER_W(PER_W)) u_calc (
    .code_i   (shadow_code),
    .period_i (period),
    .cmp_o    (next_cmp)
  );

  pwm_period_gen #(.PER_W(PER_W)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .period_i (period),
    .cmp_i    (next_cmp),
    .pwm_o    (pwm_out)
  );
endmodule

// File: rtl/pwm_duty_tx_chk.sv
module pwm_duty_tx_chk
  import pwm_tx_pkg::*;
#(
  parameter int unsigned PER_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             pwm,
  input logic             on,
  input logic             wrap,
  input logic [PER_W-1:0] cnt,
  input logic [PER_W-1:0] act_per,
  input logic [PER_W-1:0] act_cmp
);
  a_r6_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm);

  a_r2_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm) |-> (cnt == '0));

  a_r2_fall_at_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pwm) && on) |-> (cnt == act_cmp));

  a_r4_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
    (on && en && !wrap) |=> ($stable(act_cmp) && $stable(act_per)));

  a_r8_cmp_window: assert property (@(posedge clk) disable iff (!rst_n)
    (on && act_per >= PER_W'(MIN_PERIOD)) |-> (act_cmp != '0 && act_cmp < act_per));
endmodule

bind pwm_period_gen pwm_duty_tx_chk #(.PER_W(PER_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .pwm     (pwm_o),
  .on      (state_q == GEN_ON),
  .wrap    (wrap),
  .cnt     (cnt_q),
  .act_per (act_per_q),
  .act_cmp (act_cmp_q)
);

// File: tb/pwm_duty_tx_tb.sv
module pwm_duty_tx_tb;
  localparam int unsigned DATA_W = 12;
  localparam int unsigned PER_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en = 1'b0;
  logic [PER_W-1:0]  period = 16'd100;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic              pwm_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pwm_duty_tx #(.DATA_W(DATA_W), .PER_W(PER_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .period(period),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .pwm_out(pwm_out)
  );

  function automatic int exp_high(int code, int per);
    longint num;
    num = longint'(per) * (longint'(1) << DATA_W) + longint'(per) * 8 * code
          + 5 * (longint'(1) << DATA_W);
    return int'(num / (10 * (longint'(1) << DATA_W)));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(int code, int per);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = DATA_W'(code);
    period   = PER_W'(per);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = DATA_W'($urandom);
  endtask

  task automatic next_rise();
    logic p;
    p = pwm_out;
    forever begin
      @(negedge clk);
      if (pwm_out && !p) break;
      p = pwm_out;
    end
  endtask

  // Called on the falling edge where a rise was seen; ends on the next rise.
  task automatic measure(output int hi, output int tot);
    bit seen_low;
    seen_low = 1'b0;
    hi = 1;
    tot = 1;
    forever begin
      @(negedge clk);
      if (pwm_out && seen_low) break;
      if (!pwm_out) seen_low = 1'b1;
      else hi++;
      tot++;
    end
  endtask

  task automatic check_word(int code, int per, string req);
    int hi, tot;
    send(code, per);
    next_rise();
    measure(hi, tot);
    chk(hi == exp_high(code, per), req, hi, exp_high(code, per));
    chk(tot == per, "R2 period length", tot, per);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hi, tot, hi2, tot2;
    void'($urandom(32'd2024));

    // R7 / R3: reset state
    repeat (3) @(negedge clk);
    chk(pwm_out == 1'b0, "R7 pwm low in reset", pwm_out, 0);
    chk(in_ready == 1'b0, "R3 ready low in reset", in_ready, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(in_ready == 1'b1, "R3 ready after reset", in_ready, 1);
    chk(pwm_out == 1'b0, "R6 idle while disabled", pwm_out, 0);

    // R6 / R7: first period after enable uses reset word 0
    period = 16'd100;
    en = 1'b1;
    @(negedge clk);
    chk(pwm_out == 1'b1, "R6 fresh period on enable", pwm_out, 1);
    measure(hi, tot);
    chk(hi == exp_high(0, 100), "R7 reset word is zero", hi, exp_high(0, 100));
    chk(tot == 100, "R2 period length", tot, 100);

    // R1 directed corners
    check_word((1 << DATA_W) - 1, 100, "R1 max word");
    check_word(0, 1000, "R1 zero word rounding");
    check_word(1 << (DATA_W - 1), 10, "R1 mid word min period");
    check_word(1234, 1001, "R1 odd period");

    // R1 random
    for (int i = 0; i < 12; i++) begin
      int c, p;
      c = int'($urandom_range((1 << DATA_W) - 1, 0));
      p = int'($urandom_range(250, 10));
      check_word(c, p, "R1 random word");
    end

    // R4: mid-period change does not disturb the running period
    send(100, 60);
    next_rise();
    fork
      measure(hi, tot);
      begin
        repeat (3) @(negedge clk);
        in_valid = 1'b1;
        in_data  = DATA_W'(4000);
        period   = 16'd80;
        @(negedge clk);
        in_valid = 1'b0;
      end
    join
    chk(hi == exp_high(100, 60), "R4 old high kept", hi, exp_high(100, 60));
    chk(tot == 60, "R4 old length kept", tot, 60);
    measure(hi, tot);
    chk(hi == exp_high(4000, 80), "R4 new word next period", hi, exp_high(4000, 80));
    chk(tot == 80, "R4 new length next period", tot, 80);

    // R5: repeat with no new word; R3: valid low ignores data
    in_data = DATA_W'(7);
    measure(hi, tot);
    measure(hi2, tot2);
    chk(hi == exp_high(4000, 80) && hi2 == hi, "R5 repeated word", hi2, exp_high(4000, 80));
    chk(tot2 == 80, "R3 data ignored without valid", tot2, 80);

    // R6: disable mid-period
    repeat (5) @(negedge clk);
    en = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(pwm_out == 1'b0, "R6 low when disabled", pwm_out, 0);
    end
    // R7: word accepted while disabled is used after enabling
    send(2048, 50);
    en = 1'b1;
    @(negedge clk);
    chk(pwm_out == 1'b1, "R6 fresh period on re-enable", pwm_out, 1);
    measure(hi, tot);
    chk(hi == exp_high(2048, 50), "R7 word kept while disabled", hi, exp_high(2048, 50));
    chk(tot == 50, "R6 counter restarted", tot, 50);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule